// File: doc/BRIEF.md
# Superscalar Register Rename Table

This block renames a dispatch group of up to `LANES` instructions in one cycle. Each instruction carries two architectural source registers and an optional architectural destination. Every destination that needs renaming gets a fresh physical register from a free pool. Each source comes back as a physical tag with a ready flag, so the consumer knows whether the value already exists or must be awaited on the result broadcast bus.

Internally the block keeps a speculative map of architectural to physical registers, a committed map that changes only when instructions retire, a free vector and a ready vector, both indexed by physical register. A retiring instruction installs its mapping in the committed map. The physical register it displaces goes back to the pool. A branch mispredict replaces the speculative map with the committed map in one cycle and rebuilds the pool to match.

Architectural register 31 is the hardwired zero register. It is never renamed and always reads as physical register 31, ready.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both maps. Physical registers 0..31 are busy and ready. Physical registers 32..63 are free.
- R2: Each lane that needs a destination, in lane order, takes the next lowest-numbered free physical register. A lane needs a destination when it is valid, has a destination, and that destination is not 31. The chosen register leaves the free pool and stays out of it until a retire displaces it.
- R3: A source that names the destination of an earlier needing lane in the same group returns the newly allocated tag of the latest such lane, with ready 0. This takes precedence over the map lookup.
- R4: Any other source returns the speculative map entry and that register's ready bit. The lookup is made whether or not the lane is valid.
- R5: When more lanes need a destination than there are free registers, `disp_stall` is 1. That cycle allocates nothing and leaves the speculative map unchanged.
- R6: A lane with no destination, an invalid lane, or a lane whose destination is register 31 reports destination tag 31. Such a lane allocates nothing and does not count toward a stall.
- R7: A tag on the result bus sets that register's ready bit from the next cycle on. A source lookup that returns the broadcast tag in the same cycle already reports ready 1.
- R8: A retire sets the committed map entry for its architectural register to its physical tag. The physical register previously held there becomes free from the next cycle. A retire naming register 31 is ignored.
- R9: On `flush`, the speculative map is replaced by the committed map, including any retire in the same cycle. The free pool becomes exactly the registers absent from that committed map, and those registers become ready. The dispatch group of that cycle is discarded.
- R10: A newly allocated register reports ready 0 until its tag is broadcast on the result bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | LANES | Lane holds an instruction |
| disp_has_dst | input | LANES | Lane writes a destination |
| disp_dst | input | LANES*5 | Destination architectural register per lane |
| disp_src_a | input | LANES*5 | First source architectural register per lane |
| disp_src_b | input | LANES*5 | Second source architectural register per lane |
| disp_stall | output | 1 | Not enough free registers for the group |
| disp_dst_tag | output | LANES*6 | Allocated physical tag per lane (31 when none) |
| src_a_tag | output | LANES*6 | Physical tag for the first source |
| src_a_rdy | output | LANES | First source is ready |
| src_b_tag | output | LANES*6 | Physical tag for the second source |
| src_b_rdy | output | LANES | Second source is ready |
| cdb_valid | input | 1 | Result broadcast present |
| cdb_tag | input | 6 | Physical tag being broadcast |
| ret_valid | input | 1 | An instruction retires |
| ret_arch | input | 5 | Retiring architectural destination |
| ret_tag | input | 6 | Retiring physical destination |
| flush | input | 1 | Mispredict: restore from the committed map |

## Verification
The properties assume well-formed traffic from the rest of the core:
- the result bus only broadcasts a tag that has been allocated and not yet broadcast;
- retires name mappings that earlier accepted groups created, in program order, and never register 31;
- a retire never names a register in the cycle it is allocated.

The stimulus keeps to these rules. It retires only renames it made earlier, in their original order. It broadcasts only tags it has just seen allocated. It raises `flush` only against a committed map built by such retires.

// File: rtl/rn_pkg.sv
`timescale 1ns/1ps
package rn_pkg;
    localparam int LANES_DEF     = 3;
    localparam int ARCH_REGS_DEF = 32;
    localparam int PHYS_REGS_DEF = 64;
endpackage

// File: rtl/rn_free_pick.sv
`timescale 1ns/1ps
module rn_free_pick #(
    parameter int PREGS = 64,
    parameter int PICKS = 3,
    localparam int PW = $clog2(PREGS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PREGS-1:0]   free_vec,
    output logic [PICKS*PW-1:0] pick_tags,
    output logic [PICKS-1:0]   pick_ok
);
    logic [PREGS-1:0] remain;
    logic             found;

    // Successive lowest-set-bit search; each round removes its winner.
    always_comb begin
        remain    = free_vec;
        pick_tags = '0;
        pick_ok   = '0;
        for (int k = 0; k < PICKS; k++) begin
            found = 1'b0;
            for (int p = 0; p < PREGS; p++) begin
                if (!found && remain[p]) begin
                    found = 1'b1;
                    pick_tags[k*PW +: PW] = PW'(p);
                    remain[p] = 1'b0;
                end
            end
            pick_ok[k] = found;
        end
    end

    for (genvar k = 0; k < PICKS; k++) begin : g_pick_chk
        // R2
        pick_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pick_ok[k] |-> free_vec[pick_tags[k*PW +: PW]]);
        if (k > 0) begin : g_order
            // R2
            pick_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pick_ok[k] |-> (pick_ok[k-1] &&
                                (pick_tags[k*PW +: PW] > pick_tags[(k-1)*PW +: PW])));
        end
    end
endmodule

// File: rtl/rn_src_fwd.sv
`timescale 1ns/1ps
module rn_src_fwd #(
    parameter int LANES = 3,
    parameter int LANE  = 0,
    parameter int AW    = 5,
    parameter int PW    = 6
) (
    input  logic [AW-1:0]       src_arch,
    input  logic [PW-1:0]       map_tag,
    input  logic                map_rdy,
    input  logic [LANES*AW-1:0] grp_dst,
    input  logic [LANES-1:0]    grp_need,
    input  logic [LANES*PW-1:0] grp_tag,
    input  logic                cdb_valid,
    input  logic [PW-1:0]       cdb_tag,
    output logic [PW-1:0]       tag,
    output logic                rdy
);
    // Map lookup with same-cycle broadcast bypass, then override by the
    // youngest older lane in the group that writes this register.
    always_comb begin
        tag = map_tag;
        rdy = map_rdy || (cdb_valid && (cdb_tag == map_tag));
        for (int j = 0; j < LANES; j++) begin
            if ((j < LANE) && grp_need[j] && (grp_dst[j*AW +: AW] == src_arch)) begin
                tag = grp_tag[j*PW +: PW];
                rdy = 1'b0;
            end
        end
    end
endmodule

// File: rtl/rename_unit.sv
`timescale 1ns/1ps
module rename_unit
    import rn_pkg::*;
#(
    parameter int LANES = LANES_DEF,
    parameter int AREGS = ARCH_REGS_DEF,
    parameter int PREGS = PHYS_REGS_DEF,
    localparam int AW = $clog2(AREGS),
    localparam int PW = $clog2(PREGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [LANES-1:0]    disp_valid,
    input  logic [LANES-1:0]    disp_has_dst,
    input  logic [LANES*AW-1:0] disp_dst,
    input  logic [LANES*AW-1:0] disp_src_a,
    input  logic [LANES*AW-1:0] disp_src_b,
    output logic                disp_stall,
    output logic [LANES*PW-1:0] disp_dst_tag,
    output logic [LANES*PW-1:0] src_a_tag,
    output logic [LANES-1:0]    src_a_rdy,
    output logic [LANES*PW-1:0] src_b_tag,
    output logic [LANES-1:0]    src_b_rdy,
    input  logic                cdb_valid,
    input  logic [PW-1:0]       cdb_tag,
    input  logic                ret_valid,
    input  logic [AW-1:0]       ret_arch,
    input  logic [PW-1:0]       ret_tag,
    input  logic                flush
);
    localparam int ZR = AREGS - 1;

    logic [PW-1:0]    spec_map [AREGS];
    logic [PW-1:0]    ret_map  [AREGS];
    logic [PW-1:0]    spec_nxt [AREGS];
    logic [PW-1:0]    ret_nxt  [AREGS];
    logic [PREGS-1:0] free_q, free_nxt, rdy_q, rdy_nxt, ret_used, cdb_mask;
    logic [LANES-1:0] need, pick_ok;
    logic [LANES*PW-1:0] pick_tags, grp_tag;
    logic [PW-1:0]    lane_tag [LANES];
    logic [PW-1:0]    ret_old;
    logic             ret_do;
    int               need_cnt, avail_cnt;

    rn_free_pick #(.PREGS(PREGS), .PICKS(LANES)) u_pick (
        .clk(clk), .rst_n(rst_n), .free_vec(free_q),
        .pick_tags(pick_tags), .pick_ok(pick_ok)
    );

    // Lane demand, rank-ordered tag hand-out, stall decision.
    always_comb begin
        int rank;
        rank = 0;
        for (int k = 0; k < LANES; k++) begin
            need[k] = disp_valid[k] && disp_has_dst[k] &&
                      (disp_dst[k*AW +: AW] != AW'(ZR));
            lane_tag[k] = pick_tags[rank*PW +: PW];
            if (need[k]) rank = rank + 1;
        end
        need_cnt  = $countones(need);
        avail_cnt = $countones(pick_ok);
        disp_stall = need_cnt > avail_cnt;
        for (int k = 0; k < LANES; k++) begin
            grp_tag[k*PW +: PW]      = lane_tag[k];
            disp_dst_tag[k*PW +: PW] = need[k] ? lane_tag[k] : PW'(ZR);
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        rn_src_fwd #(.LANES(LANES), .LANE(k), .AW(AW), .PW(PW)) u_fwd_a (
            .src_arch(disp_src_a[k*AW +: AW]),
            .map_tag(spec_map[disp_src_a[k*AW +: AW]]),
            .map_rdy(rdy_q[spec_map[disp_src_a[k*AW +: AW]]]),
            .grp_dst(disp_dst), .grp_need(need), .grp_tag(grp_tag),
            .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
            .tag(src_a_tag[k*PW +: PW]), .rdy(src_a_rdy[k])
        );
        rn_src_fwd #(.LANES(LANES), .LANE(k), .AW(AW), .PW(PW)) u_fwd_b (
            .src_arch(disp_src_b[k*AW +: AW]),
            .map_tag(spec_map[disp_src_b[k*AW +: AW]]),
            .map_rdy(rdy_q[spec_map[disp_src_b[k*AW +: AW]]]),
            .grp_dst(disp_dst), .grp_need(need), .grp_tag(grp_tag),
            .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
            .tag(src_b_tag[k*PW +: PW]), .rdy(src_b_rdy[k])
        );
    end

    assign ret_do  = ret_valid && (ret_arch != AW'(ZR));
    assign ret_old = ret_map[ret_arch];

    // Next-state for both maps, the free pool and the ready bits.
    always_comb begin
        ret_nxt = ret_map;
        if (ret_do) ret_nxt[ret_arch] = ret_tag;
        ret_used = '0;
        for (int i = 0; i < AREGS; i++) ret_used[ret_nxt[i]] = 1'b1;
        cdb_mask = '0;
        if (cdb_valid) cdb_mask[cdb_tag] = 1'b1;
        spec_nxt = spec_map;
        free_nxt = free_q;
        rdy_nxt  = rdy_q | cdb_mask;
        if (flush) begin
            spec_nxt = ret_nxt;
            free_nxt = ~ret_used;
            rdy_nxt  = rdy_q | ret_used | cdb_mask;
        end else begin
            if (ret_do) free_nxt[ret_old] = 1'b1;
            if (!disp_stall) begin
                for (int k = 0; k < LANES; k++) begin
                    if (need[k]) begin
                        spec_nxt[disp_dst[k*AW +: AW]] = lane_tag[k];
                        free_nxt[lane_tag[k]] = 1'b0;
                        rdy_nxt[lane_tag[k]]  = 1'b0;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < AREGS; i++) begin
                spec_map[i] <= PW'(i);
                ret_map[i]  <= PW'(i);
            end
            for (int p = 0; p < PREGS; p++) begin
                free_q[p] <= (p >= AREGS);
                rdy_q[p]  <= (p < AREGS);
            end
        end else begin
            spec_map <= spec_nxt;
            ret_map  <= ret_nxt;
            free_q   <= free_nxt;
            rdy_q    <= rdy_nxt;
        end
    end

    for (genvar k = 0; k < LANES; k++) begin : g_alloc_chk
        // R10
        alloc_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!flush && !disp_stall && need[k]) |=>
            (!free_q[$past(lane_tag[k])] && !rdy_q[$past(lane_tag[k])]));
    end

    for (genvar i = 0; i < AREGS; i++) begin : g_flush_chk
        // R9
        flush_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
            flush |=> (spec_map[i] == ret_map[i]));
    end

    // R7
    cdb_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cdb_valid |=> rdy_q[$past(cdb_tag)]);

    // R8
    retire_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_do && !flush) |=> free_q[$past(ret_old)]);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_stall && !flush && !ret_valid) |=> $stable(free_q));

    // R6
    zero_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_map[ZR] == PW'(ZR)) && (ret_map[ZR] == PW'(ZR)));
endmodule

// File: tb/rename_unit_test.sv
`timescale 1ns/1ps
module rename_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  v, hd;
    logic [4:0]  d [3];
    logic [4:0]  a [3];
    logic [4:0]  b [3];
    logic        disp_stall;
    logic [17:0] disp_dst_tag, src_a_tag, src_b_tag;
    logic [2:0]  src_a_rdy, src_b_rdy;
    logic        cdb_valid, ret_valid, flush;
    logic [5:0]  cdb_tag, ret_tag;
    logic [4:0]  ret_arch;
    int          nchk = 0;
    int          nfail = 0;

    always #10 clk = ~clk;

    rename_unit uut (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(v), .disp_has_dst(hd),
        .disp_dst({d[2], d[1], d[0]}),
        .disp_src_a({a[2], a[1], a[0]}),
        .disp_src_b({b[2], b[1], b[0]}),
        .disp_stall(disp_stall), .disp_dst_tag(disp_dst_tag),
        .src_a_tag(src_a_tag), .src_a_rdy(src_a_rdy),
        .src_b_tag(src_b_tag), .src_b_rdy(src_b_rdy),
        .cdb_valid(cdb_valid), .cdb_tag(cdb_tag),
        .ret_valid(ret_valid), .ret_arch(ret_arch), .ret_tag(ret_tag),
        .flush(flush)
    );

    typedef struct packed {
        logic [2:0] v, hd;
        logic [4:0] d0, d1, d2, a0, a1, a2, b0, b1, b2;
        logic       st;
        logic [5:0] t0, t1, t2, ta0, ta1, ta2, tb0, tb1, tb2;
        logic [2:0] ra, rb;
    } vec_t;

    // Three consecutive groups from reset; rdy fields are {lane2,lane1,lane0}.
    localparam vec_t VECS [3] = '{
        '{3'b111, 3'b111, 5'd1, 5'd4, 5'd1, 5'd2, 5'd1, 5'd4, 5'd3, 5'd1, 5'd1, 1'b0,
          6'd32, 6'd33, 6'd34, 6'd2, 6'd32, 6'd33, 6'd3, 6'd32, 6'd32, 3'b001, 3'b001},
        '{3'b111, 3'b110, 5'd0, 5'd31, 5'd5, 5'd1, 5'd31, 5'd5, 5'd4, 5'd5, 5'd1, 1'b0,
          6'd31, 6'd31, 6'd35, 6'd34, 6'd31, 6'd5, 6'd33, 6'd5, 6'd34, 3'b110, 3'b010},
        '{3'b101, 3'b111, 5'd6, 5'd8, 5'd9, 5'd6, 5'd0, 5'd8, 5'd7, 5'd0, 5'd6, 1'b0,
          6'd36, 6'd31, 6'd37, 6'd6, 6'd0, 6'd8, 6'd7, 6'd0, 6'd36, 3'b111, 3'b011}
    };

    function automatic int fld(input logic [17:0] vec, input int k);
        return int'(vec[k*6 +: 6]);
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
    endtask

    task automatic grp(input logic [2:0] vv, input logic [2:0] hh,
                       input int d0, input int d1, input int d2,
                       input int a0, input int a1, input int a2,
                       input int b0, input int b1, input int b2);
        @(negedge clk);
        v = vv; hd = hh;
        d[0] = 5'(d0); d[1] = 5'(d1); d[2] = 5'(d2);
        a[0] = 5'(a0); a[1] = 5'(a1); a[2] = 5'(a2);
        b[0] = 5'(b0); b[1] = 5'(b1); b[2] = 5'(b2);
        cdb_valid = 1'b0; cdb_tag = '0;
        ret_valid = 1'b0; ret_arch = '0; ret_tag = '0;
        flush = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        v = '0; hd = '0;
        for (int k = 0; k < 3; k++) begin d[k] = '0; a[k] = '0; b[k] = '0; end
        cdb_valid = 1'b0; cdb_tag = '0; ret_valid = 1'b0; ret_arch = '0;
        ret_tag = '0; flush = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state seen through lookups
        grp(3'b000, 3'b000, 0, 0, 0, 0, 17, 30, 31, 5, 9);
        #2;
        chk("R1", "stall", int'(disp_stall), 0);
        chk("R1", "a tag l1", fld(src_a_tag, 1), 17);
        chk("R1", "a tag l2", fld(src_a_tag, 2), 30);
        chk("R1", "b tag l0", fld(src_b_tag, 0), 31);
        chk("R1", "a rdy", int'(src_a_rdy), 7);
        chk("R1", "b rdy", int'(src_b_rdy), 7);
        chk("R6", "dst l0 idle", fld(disp_dst_tag, 0), 31);

        // R2 R3 R4 R6 table of groups
        for (int i = 0; i < 3; i++) begin
            grp(VECS[i].v, VECS[i].hd, VECS[i].d0, VECS[i].d1, VECS[i].d2,
                VECS[i].a0, VECS[i].a1, VECS[i].a2, VECS[i].b0, VECS[i].b1, VECS[i].b2);
            #2;
            chk("R5", "stall", int'(disp_stall), int'(VECS[i].st));
            chk("R2", "dst l0", fld(disp_dst_tag, 0), int'(VECS[i].t0));
            chk("R2", "dst l1", fld(disp_dst_tag, 1), int'(VECS[i].t1));
            chk("R2", "dst l2", fld(disp_dst_tag, 2), int'(VECS[i].t2));
            chk("R3", "a l0", fld(src_a_tag, 0), int'(VECS[i].ta0));
            chk("R3", "a l1", fld(src_a_tag, 1), int'(VECS[i].ta1));
            chk("R3", "a l2", fld(src_a_tag, 2), int'(VECS[i].ta2));
            chk("R4", "b l0", fld(src_b_tag, 0), int'(VECS[i].tb0));
            chk("R4", "b l1", fld(src_b_tag, 1), int'(VECS[i].tb1));
            chk("R4", "b l2", fld(src_b_tag, 2), int'(VECS[i].tb2));
            chk("R3", "a rdy", int'(src_a_rdy), int'(VECS[i].ra));
            chk("R4", "b rdy", int'(src_b_rdy), int'(VECS[i].rb));
        end

        // R7 same-cycle bypass for tag 34 (r1)
        grp(3'b000, 3'b000, 0, 0, 0, 1, 4, 5, 0, 0, 0);
        cdb_valid = 1'b1; cdb_tag = 6'd34;
        #2;
        chk("R7", "bypass rdy", int'(src_a_rdy), 3'b001);
        grp(3'b000, 3'b000, 0, 0, 0, 1, 4, 5, 0, 0, 0);
        #2;
        chk("R7", "held rdy", int'(src_a_rdy[0]), 1);
        chk("R10", "r4 unbroadcast", int'(src_a_rdy[1]), 0);
        chk("R10", "r5 unbroadcast", int'(src_a_rdy[2]), 0);

        // R8 retires free the displaced registers 1, 4, 32
        grp(3'b000, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        ret_valid = 1'b1; ret_arch = 5'd1; ret_tag = 6'd32;
        grp(3'b000, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        ret_valid = 1'b1; ret_arch = 5'd4; ret_tag = 6'd33;
        grp(3'b000, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        ret_valid = 1'b1; ret_arch = 5'd1; ret_tag = 6'd34;
        grp(3'b111, 3'b111, 10, 11, 12, 0, 0, 0, 0, 0, 0);
        #2;
        chk("R8", "reuse l0", fld(disp_dst_tag, 0), 1);
        chk("R8", "reuse l1", fld(disp_dst_tag, 1), 4);
        chk("R8", "reuse l2", fld(disp_dst_tag, 2), 32);

        // R2 drain the pool: 38..61
        for (int g = 0; g < 8; g++) begin
            grp(3'b111, 3'b111, 13, 13, 13, 0, 0, 0, 0, 0, 0);
            #2;
            for (int k = 0; k < 3; k++)
                chk("R2", "fill dst", fld(disp_dst_tag, k), 38 + 3*g + k);
        end

        // R5 two free, three requested
        grp(3'b111, 3'b111, 14, 15, 16, 13, 0, 0, 0, 0, 0);
        #2;
        chk("R5", "stall 3>2", int'(disp_stall), 1);
        chk("R3", "r13 newest", fld(src_a_tag, 0), 61);
        grp(3'b000, 3'b000, 0, 0, 0, 14, 0, 0, 0, 0, 0);
        #2;
        chk("R5", "map kept", fld(src_a_tag, 0), 14);
        grp(3'b011, 3'b011, 14, 15, 0, 0, 0, 0, 0, 0, 0);
        #2;
        chk("R5", "exact fit", int'(disp_stall), 0);
        chk("R2", "last l0", fld(disp_dst_tag, 0), 62);
        chk("R2", "last l1", fld(disp_dst_tag, 1), 63);
        grp(3'b001, 3'b001, 16, 0, 0, 0, 0, 0, 0, 0, 0);
        #2;
        chk("R5", "empty pool", int'(disp_stall), 1);
        grp(3'b001, 3'b001, 31, 0, 0, 0, 0, 0, 0, 0, 0);
        #2;
        chk("R6", "zero dst no stall", int'(disp_stall), 0);
        chk("R6", "zero dst tag", fld(disp_dst_tag, 0), 31);

        // R9 flush with a same-cycle retire and a discarded group
        grp(3'b111, 3'b111, 6, 7, 8, 0, 0, 0, 0, 0, 0);
        flush = 1'b1; ret_valid = 1'b1; ret_arch = 5'd5; ret_tag = 6'd35;
        grp(3'b000, 3'b000, 0, 0, 0, 1, 5, 6, 13, 10, 14);
        #2;
        chk("R9", "r1", fld(src_a_tag, 0), 34);
        chk("R9", "r5", fld(src_a_tag, 1), 35);
        chk("R9", "r6 group dropped", fld(src_a_tag, 2), 6);
        chk("R9", "r13", fld(src_b_tag, 0), 13);
        chk("R9", "r10", fld(src_b_tag, 1), 10);
        chk("R9", "r14", fld(src_b_tag, 2), 14);
        chk("R9", "a rdy", int'(src_a_rdy), 7);
        chk("R9", "b rdy", int'(src_b_rdy), 7);
        grp(3'b111, 3'b111, 20, 21, 22, 0, 0, 0, 0, 0, 0);
        #2;
        chk("R9", "pool l0", fld(disp_dst_tag, 0), 1);
        chk("R9", "pool l1", fld(disp_dst_tag, 1), 4);
        chk("R9", "pool l2", fld(disp_dst_tag, 2), 5);
        grp(3'b111, 3'b111, 23, 24, 25, 0, 0, 0, 0, 0, 0);
        #2;
        chk("R9", "pool next l0", fld(disp_dst_tag, 0), 32);
        chk("R9", "pool next l1", fld(disp_dst_tag, 1), 36);
        chk("R9", "pool next l2", fld(disp_dst_tag, 2), 37);

        grp(3'b000, 3'b000, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        summary();
        $finish;
    end
endmodule